// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block keeps a free-running counter and an alarm value of the same width, and raises a timer interrupt when the counter steps onto the alarm value. The counter advances by one on every cycle in which the tick input is high, unless the freeze input holds it. Software may load either register at any time through two write strobes that share a data bus, and may read either register back through a select-driven read port.

When a counting step lands the counter on the alarm value, a pending flag is set. The flag drives one of eight interrupt lines, chosen by a 3-bit select. The interrupt stays up until software writes the alarm register, which is the only way to acknowledge it. A build parameter decides whether the pending flag is also shown on its own output pin. The interrupt lines behave the same either way. All pins are plain control and status signals: writes are single-cycle strobes with no back-pressure, and reads are combinational.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset the counter reads 1, the alarm register reads 0, the pending output is 0 and all interrupt lines are 0.
- R2: On a clock edge with tick high, freeze low and no counter write, the counter becomes its old value plus one, wrapping from all ones to zero. With tick low it holds.
- R3: While freeze is high the counter holds its value even when tick is high.
- R4: A counter write (wr_count_i) loads wr_data_i on the next edge, whether freeze is high or low and whether tick is high or low.
- R5: An alarm write (wr_compare_i) loads wr_data_i into the alarm register, and on the same edge clears the pending flag and drops every interrupt line.
- R6: When a counting step (see R2) makes the counter equal to the alarm value, including a step that wraps to zero, the pending flag is set on that same edge.
- R7: Once set, the pending flag and its interrupt line stay asserted while the counter moves past the alarm value, until an alarm write.
- R8: Equality reached by a counter write, or held while freeze is high, never sets the pending flag.
- R9: When both write strobes are high in one cycle, both registers load wr_data_i, and no interrupt is raised by that edge.
- R10: irq_o is zero when nothing is pending. Otherwise exactly bit line_sel_i is set (line_sel_i = 5 gives 8'h20), and this follows line_sel_i combinationally.
- R11: pending_o shows the flag only when SHOW_PENDING is 1 and is tied to 0 otherwise. irq_o does not depend on SHOW_PENDING.
- R12: rd_data_o returns the counter when rd_sel_i is 0 and the alarm register when rd_sel_i is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable pulse, one step per high cycle |
| freeze_i | input | 1 | Holds the counter while high |
| wr_count_i | input | 1 | Write strobe for the counter |
| wr_compare_i | input | 1 | Write strobe for the alarm register, also acknowledges the interrupt |
| wr_data_i | input | WIDTH | Write data for both strobes |
| rd_sel_i | input | 1 | Read select: 0 counter, 1 alarm |
| rd_data_o | output | WIDTH | Read data |
| line_sel_i | input | SEL_W | Chooses which interrupt line carries the alarm |
| irq_o | output | LINES | Interrupt line vector |
| pending_o | output | 1 | Pending flag when SHOW_PENDING is 1, else 0 |

## Verification
On every cycle the assertions check the counter step, the freeze hold, the direct load, the acknowledge on alarm writes, that the flag stays set, that no flag appears without a counting step, and that the interrupt vector is one-hot and agrees with the flag. Only the bench's scenarios can show the full picture. These include the exact cycle on which the alarm fires, the wrap from all ones to zero, the counter moving past the alarm value while the line stays up, and the line moving when the select changes. They also include the same-cycle double write and the hidden-flag build variant, which need chosen values and a second instance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    RD_COUNT   = 1'b0,
    RD_COMPARE = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned WIDTH      = 32,
  parameter logic [WIDTH-1:0] RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             wr_count_i,
  input  logic             wr_compare_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] compare_i,
  output logic [WIDTH-1:0] count_o,
  output logic             hit_o
);
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_inc;
  logic             step;

  assign step      = tick_i && !freeze_i;
  assign count_inc = count_q + WIDTH'(1);

  // only a genuine counting step may raise the alarm
  assign hit_o = step && !wr_count_i && !wr_compare_i && (count_inc == compare_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)         count_q <= RST_VAL;
    else if (wr_count_i) count_q <= wr_data_i;
    else if (step)       count_q <= count_inc;
  end

  assign count_o = count_q;
endmodule

// File: rtl/tmr_alarm.sv
module tmr_alarm #(
  parameter int unsigned WIDTH      = 32,
  parameter logic [WIDTH-1:0] RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_compare_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             hit_i,
  output logic [WIDTH-1:0] compare_o,
  output logic             pending_o
);
  logic [WIDTH-1:0] compare_q;
  logic             pending_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      compare_q <= RST_VAL;
      pending_q <= 1'b0;
    end else begin
      if (wr_compare_i) compare_q <= wr_data_i;
      if (wr_compare_i)  pending_q <= 1'b0;
      else if (hit_i)    pending_q <= 1'b1;
    end
  end

  assign compare_o = compare_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route #(
  parameter int unsigned LINES = 8,
  localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             pending_i,
  input  logic [SEL_W-1:0] line_sel_i,
  output logic [LINES-1:0] irq_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign irq_o[i] = pending_i && (line_sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
  parameter int unsigned WIDTH        = 32,
  parameter int unsigned LINES        = 8,
  parameter bit          SHOW_PENDING = 1'b1,
  localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             wr_count_i,
  input  logic             wr_compare_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_sel_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic [SEL_W-1:0] line_sel_i,
  output logic [LINES-1:0] irq_o,
  output logic             pending_o
);
  import tmr_pkg::*;

  localparam logic [WIDTH-1:0] COUNT_RST   = WIDTH'(1);
  localparam logic [WIDTH-1:0] COMPARE_RST = '0;

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] compare_q;
  logic             pending_q;
  logic             hit;

  tmr_counter #(.WIDTH(WIDTH), .RST_VAL(COUNT_RST)) u_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .freeze_i     (freeze_i),
    .wr_count_i   (wr_count_i),
    .wr_compare_i (wr_compare_i),
    .wr_data_i    (wr_data_i),
    .compare_i    (compare_q),
    .count_o      (count_q),
    .hit_o        (hit)
  );

  tmr_alarm #(.WIDTH(WIDTH), .RST_VAL(COMPARE_RST)) u_alarm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_compare_i (wr_compare_i),
    .wr_data_i    (wr_data_i),
    .hit_i        (hit),
    .compare_o    (compare_q),
    .pending_o    (pending_q)
  );

  tmr_irq_route #(.LINES(LINES)) u_route (
    .pending_i  (pending_q),
    .line_sel_i (line_sel_i),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      RD_COMPARE: rd_data_o = compare_q;
      default:    rd_data_o = count_q;
    endcase
  end

  if (SHOW_PENDING) begin : g_show
    assign pending_o = pending_q;
  end else begin : g_hide
    assign pending_o = 1'b0;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned LINES = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             freeze_i,
  input logic             wr_count_i,
  input logic             wr_compare_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] count_q,
  input logic             pending_q,
  input logic [LINES-1:0] irq_o
);
  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !freeze_i && !wr_count_i) |=> (count_q == $past(count_q) + WIDTH'(1)));

  // R3
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !wr_count_i) |=> $stable(count_q));

  // R4
  count_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_count_i |=> (count_q == $past(wr_data_i)));

  // R5
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_compare_i |=> (!pending_q && (irq_o == '0)));

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !wr_compare_i) |=> pending_q);

  // R8
  no_step_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_q && !(tick_i && !freeze_i)) |=> !pending_q);

  // R9
  dual_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_count_i && wr_compare_i) |=> !pending_q);

  // R10
  irq_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o) && (pending_q == (irq_o != '0)));
endmodule

bind tick_compare_timer tmr_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .freeze_i     (freeze_i),
  .wr_count_i   (wr_count_i),
  .wr_compare_i (wr_compare_i),
  .wr_data_i    (wr_data_i),
  .count_q      (count_q),
  .pending_q    (pending_q),
  .irq_o        (irq_o)
);

// File: tb/test_tick_compare_timer.sv
module test_tick_compare_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        freeze = 1'b0;
  logic        wr_count = 1'b0;
  logic        wr_compare = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [2:0]  line_sel = 3'd5;
  logic [31:0] rd_data, rd_data_h;
  logic [7:0]  irq, irq_h;
  logic        pending, pending_h;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tick_compare_timer i_tick_compare_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freeze_i(freeze),
    .wr_count_i(wr_count), .wr_compare_i(wr_compare), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .line_sel_i(line_sel),
    .irq_o(irq), .pending_o(pending));

  tick_compare_timer #(.SHOW_PENDING(1'b0)) i_hidden (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freeze_i(freeze),
    .wr_count_i(wr_count), .wr_compare_i(wr_compare), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data_h), .line_sel_i(line_sel),
    .irq_o(irq_h), .pending_o(pending_h));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_count(output logic [31:0] v);
    rd_sel = 1'b0; #1; v = rd_data;
  endtask

  task automatic read_compare(output logic [31:0] v);
    rd_sel = 1'b1; #1; v = rd_data; rd_sel = 1'b0;
  endtask

  // all drives happen at negedge; results are read at the following negedge
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic write_reg(input bit to_compare, input logic [31:0] d);
    wr_data = d;
    if (to_compare) wr_compare = 1'b1; else wr_count = 1'b1;
    @(negedge clk);
    wr_compare = 1'b0; wr_count = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    read_count(v);   check("R1 count", v, 32'd1);
    read_compare(v); check("R1 compare", v, 32'd0);
    check("R1 irq", {24'd0, irq}, 32'd0);
    check("R1 pending", {31'd0, pending}, 32'd0);
  endtask

  task automatic t_counting;
    logic [31:0] v;
    ticks(5); read_count(v); check("R2 step", v, 32'd6);
    repeat (3) @(negedge clk);
    read_count(v); check("R2 idle hold", v, 32'd6);
  endtask

  task automatic t_freeze;
    logic [31:0] v;
    freeze = 1'b1;
    ticks(4); read_count(v); check("R3 frozen", v, 32'd6);
    write_reg(1'b0, 32'd100); read_count(v); check("R4 load frozen", v, 32'd100);
    freeze = 1'b0;
    tick = 1'b1; write_reg(1'b0, 32'd40); tick = 1'b0;
    read_count(v); check("R4 load beats tick", v, 32'd40);
  endtask

  task automatic t_match;
    logic [31:0] v;
    write_reg(1'b1, 32'd200);
    write_reg(1'b0, 32'd197);
    ticks(2); check("R6 before match", {24'd0, irq}, 32'd0);
    ticks(1); read_count(v); check("R6 count at match", v, 32'd200);
    check("R6 R10 irq line 5", {24'd0, irq}, 32'h20);
    check("R6 pending", {31'd0, pending}, 32'd1);
    check("R11 hidden flag", {31'd0, pending_h}, 32'd0);
    check("R11 hidden irq", {24'd0, irq_h}, 32'h20);
    line_sel = 3'd2; #1;
    check("R10 reroute", {24'd0, irq}, 32'h04);
    ticks(3); check("R7 sticky", {24'd0, irq}, 32'h04);
    write_reg(1'b1, 32'd500);
    check("R5 ack irq", {24'd0, irq}, 32'd0);
    check("R5 ack pending", {31'd0, pending}, 32'd0);
    read_compare(v); check("R12 compare read", v, 32'd500);
    read_count(v); check("R12 count read", v, 32'd203);
  endtask

  task automatic t_no_retrigger;
    logic [31:0] v;
    freeze = 1'b1;
    write_reg(1'b0, 32'd500);
    check("R8 equal by write", {24'd0, irq}, 32'd0);
    ticks(3); check("R8 equal while frozen", {24'd0, irq}, 32'd0);
    freeze = 1'b0;
    ticks(1); read_count(v); check("R8 moved on", v, 32'd501);
    check("R8 no irq", {24'd0, irq}, 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    write_reg(1'b1, 32'd0);
    write_reg(1'b0, 32'hFFFF_FFFF);
    ticks(1); read_count(v); check("R2 wrap", v, 32'd0);
    check("R6 wrap match", {24'd0, irq}, 32'h04);
    write_reg(1'b1, 32'd77);
    check("R5 clear after wrap", {24'd0, irq}, 32'd0);
  endtask

  task automatic t_dual_write;
    logic [31:0] v;
    write_reg(1'b1, 32'd10);
    write_reg(1'b0, 32'd9);
    tick = 1'b1; wr_data = 32'd10; wr_count = 1'b1; wr_compare = 1'b1;
    @(negedge clk);
    tick = 1'b0; wr_count = 1'b0; wr_compare = 1'b0;
    check("R9 no irq", {24'd0, irq}, 32'd0);
    read_count(v); check("R9 count", v, 32'd10);
    read_compare(v); check("R9 compare", v, 32'd10);
    ticks(1); check("R9 later step", {24'd0, irq}, 32'd0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_counting;
    t_freeze;
    t_match;
    t_no_retrigger;
    t_wrap;
    t_dual_write;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run;
  end
endmodule